// File: doc/BRIEF.md
# Three-Wire Audio Control Register Receiver

This block is a write-only slave on a three-wire control bus with a mode line, a serial clock and a serial data line. The controller first sends an address byte while the mode line is low. That byte names the target device and picks the register bank that the data transfers after it will write. One bank holds audio feature settings: right volume, left volume, bass and treble. The other bank holds general control words. Data never flows back to the controller.

The mode line, serial clock and serial data line are asynchronous to the block clock. Each one passes through a two-stage synchronizer. The block takes a bit on each rising edge of the synchronized serial clock, so each serial-clock level must stay steady for at least three block clocks. A data transfer is sent with the mode line high and carries two bytes: a register index and then a value. The controller ends it by dropping the mode line for a halt period. A bank selection stays in force until the next complete address byte, so one address can be followed by any number of data transfers.

Top module: `tw_ctrl_rx`

## Requirements
- R1: After reset, every register output is 0x00 and no write strobe is high.
- R2: Bits arrive LSB first on rising serial-clock edges. With the mode line low, a complete byte is an address byte: bits [7:2] are the device address and bits [1:0] are the type. If the address equals DEV_ADDR, type 2'b00 selects the feature bank and type 2'b10 selects the control bank.
- R3: An address byte with type 2'b01 or 2'b11 selects no bank, and the data transfers that follow write nothing.
- R4: An address byte whose bits [7:2] differ from DEV_ADDR selects no bank, and the data transfers that follow write nothing.
- R5: With the mode line high, the first byte of a transfer is the register index and the second byte is the value. In the feature bank, index 0 writes right volume, 1 writes left volume, 2 writes bass and 3 writes treble.
- R6: In the control bank, index k below NUM_CTRL writes control word k, which appears at ctrl_o[8k+7:8k]. An index of NUM_CTRL or more writes nothing.
- R7: A bank selection holds across halts. Every later data transfer writes the selected bank until another address byte completes.
- R8: A register changes only when a whole value byte has been received. Any change of the mode line drops the partial bits, so a transfer cut short writes nothing.
- R9: Each write raises the strobe of the written register, and only that strobe, for exactly one clock. Bytes after the second one in the same transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Bus mode line: low for address, high for data (asynchronous) |
| sclk_i | input | 1 | Bus serial clock (asynchronous) |
| sdata_i | input | 1 | Bus serial data (asynchronous) |
| vol_r_o | output | 8 | Right volume register |
| vol_l_o | output | 8 | Left volume register |
| bass_o | output | 8 | Bass register |
| treble_o | output | 8 | Treble register |
| feat_stb_o | output | 4 | Feature write strobes: bit 0 right volume, 1 left volume, 2 bass, 3 treble |
| ctrl_o | output | NUM_CTRL*8 | Control words, word k at bits [8k+7:8k] |
| ctrl_stb_o | output | NUM_CTRL | Control word write strobes |

## Verification
The bench checks that the bank selection survives several halts. A design that cleared the selection at each halt would drop the second and later transfers. It sends address bytes with a wrong device address and with each unused type. A design that decoded only one type bit, or ignored the address, would write a register. It cuts a value byte short after five bits and then sends a normal transfer. A design that kept partial bits would write early or store a shifted value. It also sends a third byte in one transfer, which a design without the done state would take as a second value, and it writes an out-of-range control index, which an unchecked decoder would alias onto an existing word.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {BANK_NONE, BANK_FEAT, BANK_CTRL} bank_e;
  typedef enum logic [1:0] {PH_IDX, PH_VAL, PH_DONE} phase_e;
  localparam int unsigned TYPE_W = 2;
  localparam logic [TYPE_W-1:0] TYPE_FEAT = 2'b00;
  localparam logic [TYPE_W-1:0] TYPE_CTRL = 2'b10;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic mode_i,
  input  logic sdata_i,
  output logic mode_o,
  output logic sdata_o,
  output logic rise_o,
  output logic mode_chg_o
);
  logic [STAGES-1:0] s_sclk, s_mode, s_data;
  logic sclk_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_sclk <= '0;
      s_mode <= '0;
      s_data <= '0;
      sclk_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      s_sclk <= {s_sclk[STAGES-2:0], sclk_i};
      s_mode <= {s_mode[STAGES-2:0], mode_i};
      s_data <= {s_data[STAGES-2:0], sdata_i};
      sclk_q <= s_sclk[STAGES-1];
      mode_q <= s_mode[STAGES-1];
    end
  end

  assign mode_o     = s_mode[STAGES-1];
  assign sdata_o    = s_data[STAGES-1];
  assign rise_o     = s_sclk[STAGES-1] & ~sclk_q;
  assign mode_chg_o = s_mode[STAGES-1] ^ mode_q;

  // R2: one sample per serial clock edge
  assert_single_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tw_deser.sv
module tw_deser #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          bit_i,
  input  logic          mode_i,
  input  logic          clr_i,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          byte_mode_o
);
  localparam int unsigned CW = $clog2(DW);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] sh_nxt;

  assign sh_nxt = {bit_i, sh_q[DW-1:1]};  // LSB first

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      byte_vld_o  <= 1'b0;
      byte_o      <= '0;
      byte_mode_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (rise_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == CW'(DW-1)) begin
          cnt_q       <= '0;
          byte_vld_o  <= 1'b1;
          byte_o      <= sh_nxt;
          byte_mode_o <= mode_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8: a completed byte is reported for one cycle only
  assert_byte_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [DW-1:0]   idx_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [N*DW-1:0] q_o,
  output logic [N-1:0]    stb_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_o[g*DW +: DW] <= '0;
        stb_o[g]        <= 1'b0;
      end else begin
        stb_o[g] <= we_i && (idx_i == DW'(g));
        if (we_i && (idx_i == DW'(g))) q_o[g*DW +: DW] <= wdata_i;
      end
    end

    // R8: a register only moves together with its strobe
    assert_hold_without_stb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_o[g] |-> $stable(q_o[g*DW +: DW]));
  end

  // R9: at most one register written per cycle
  assert_onehot_stb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_o));
endmodule

// File: rtl/tw_ctrl_rx.sv
module tw_ctrl_rx
  import tw_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned NUM_CTRL = 4,
  parameter int unsigned SYNC_STG = 2,
  parameter logic [DW-TYPE_W-1:0] DEV_ADDR = 6'h05
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  output logic [DW-1:0]          vol_r_o,
  output logic [DW-1:0]          vol_l_o,
  output logic [DW-1:0]          bass_o,
  output logic [DW-1:0]          treble_o,
  output logic [3:0]             feat_stb_o,
  output logic [NUM_CTRL*DW-1:0] ctrl_o,
  output logic [NUM_CTRL-1:0]    ctrl_stb_o
);
  localparam int unsigned NFEAT = 4;

  logic mode_s, sdata_s, rise, mode_chg;
  logic byte_vld, byte_mode;
  logic [DW-1:0] byte_d;
  logic [DW-1:0] idx_q;
  bank_e  bank_q;
  phase_e phase_q;
  logic we, feat_we, ctrl_we;
  logic [NFEAT*DW-1:0] feat_q;

  tw_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .mode_i(mode_i),
    .sdata_i(sdata_i), .mode_o(mode_s), .sdata_o(sdata_s), .rise_o(rise),
    .mode_chg_o(mode_chg)
  );

  tw_deser #(.DW(DW)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .bit_i(sdata_s),
    .mode_i(mode_s), .clr_i(mode_chg), .byte_vld_o(byte_vld),
    .byte_o(byte_d), .byte_mode_o(byte_mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= BANK_NONE;
      phase_q <= PH_IDX;
      idx_q   <= '0;
    end else if (mode_chg) begin
      phase_q <= PH_IDX;  // halt or mode switch starts a fresh transfer
    end else if (byte_vld) begin
      if (!byte_mode) begin
        if (byte_d[DW-1:TYPE_W] != DEV_ADDR)        bank_q <= BANK_NONE;
        else if (byte_d[TYPE_W-1:0] == TYPE_FEAT)   bank_q <= BANK_FEAT;
        else if (byte_d[TYPE_W-1:0] == TYPE_CTRL)   bank_q <= BANK_CTRL;
        else                                        bank_q <= BANK_NONE;
      end else begin
        unique case (phase_q)
          PH_IDX: begin
            idx_q   <= byte_d;
            phase_q <= PH_VAL;
          end
          PH_VAL:  phase_q <= PH_DONE;
          default: phase_q <= PH_DONE;
        endcase
      end
    end
  end

  assign we      = byte_vld && byte_mode && !mode_chg && (phase_q == PH_VAL);
  assign feat_we = we && (bank_q == BANK_FEAT);
  assign ctrl_we = we && (bank_q == BANK_CTRL);

  tw_reg_bank #(.N(NFEAT), .DW(DW)) u_feat (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(feat_we), .idx_i(idx_q),
    .wdata_i(byte_d), .q_o(feat_q), .stb_o(feat_stb_o)
  );

  tw_reg_bank #(.N(NUM_CTRL), .DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl_we), .idx_i(idx_q),
    .wdata_i(byte_d), .q_o(ctrl_o), .stb_o(ctrl_stb_o)
  );

  assign vol_r_o  = feat_q[0*DW +: DW];
  assign vol_l_o  = feat_q[1*DW +: DW];
  assign bass_o   = feat_q[2*DW +: DW];
  assign treble_o = feat_q[3*DW +: DW];

  // R9: never both banks in one cycle
  assert_single_bank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|feat_stb_o) && (|ctrl_stb_o)));
  // R2: feature strobes only while the feature bank is selected
  assert_feat_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|feat_stb_o) |-> (bank_q == BANK_FEAT));
  // R3/R4: no write without a selected bank
  assert_no_bank_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_q == BANK_NONE && $past(bank_q) == BANK_NONE) |-> !(|feat_stb_o || |ctrl_stb_o));
endmodule

// File: tb/sim_tw_ctrl_rx.sv
module sim_tw_ctrl_rx;
  localparam int HALF = 4;
  localparam logic [5:0] DEV = 6'h05;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic [7:0] vol_r, vol_l, bass, treble;
  logic [3:0] feat_stb, ctrl_stb;
  logic [31:0] ctrl;
  int fcnt[4];
  int ccnt[4];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tw_ctrl_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sclk_i(sclk), .sdata_i(sdata),
    .vol_r_o(vol_r), .vol_l_o(vol_l), .bass_o(bass), .treble_o(treble),
    .feat_stb_o(feat_stb), .ctrl_o(ctrl), .ctrl_stb_o(ctrl_stb)
  );

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (feat_stb[i]) fcnt[i]++;
      if (ctrl_stb[i]) ccnt[i]++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      sdata = b[i];
      sclk = 1'b0;
      idle(HALF);
      sclk = 1'b1;
      idle(HALF);
    end
    sclk = 1'b0;
    idle(HALF);
  endtask

  task automatic set_mode(logic m);
    mode = m;
    idle(HALF);
  endtask

  task automatic addr(logic [5:0] dev, logic [1:0] typ);
    set_mode(1'b0);
    send_bits({dev, typ}, 8);
  endtask

  task automatic xfer(logic [7:0] idx, logic [7:0] val);
    set_mode(1'b1);
    send_bits(idx, 8);
    send_bits(val, 8);
    set_mode(1'b0);
    idle(8);
  endtask

  task automatic t_reset;
    chk("R1 vol_r", vol_r, 0); chk("R1 vol_l", vol_l, 0);
    chk("R1 bass", bass, 0);   chk("R1 treble", treble, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 strobes", {feat_stb, ctrl_stb}, 0);
  endtask

  task automatic t_feature;
    addr(DEV, 2'b00);
    xfer(8'd0, 8'h11); xfer(8'd1, 8'h22); xfer(8'd2, 8'h33); xfer(8'd3, 8'h44);
    chk("R5 vol_r", vol_r, 8'h11); chk("R5 vol_l", vol_l, 8'h22);
    chk("R5 bass", bass, 8'h33);   chk("R5 treble", treble, 8'h44);
    chk("R2 ctrl untouched", ctrl, 0);
    for (int i = 0; i < 4; i++) chk("R9 one strobe cycle per write", fcnt[i], 1);
  endtask

  task automatic t_control;
    addr(DEV, 2'b10);
    xfer(8'd2, 8'hA5);
    chk("R6 ctrl word 2", ctrl, 32'h00A5_0000);
    chk("R6 feature untouched", {vol_r, vol_l, bass, treble}, 32'h1122_3344);
    chk("R9 ctrl strobe", ccnt[2], 1);
    xfer(8'd4, 8'h33);
    chk("R6 out of range ignored", ctrl, 32'h00A5_0000);
    chk("R6 no strobe out of range", ccnt[0] + ccnt[1] + ccnt[2] + ccnt[3], 1);
    idle(40);
    xfer(8'd0, 8'h5A);
    chk("R7 selection kept", ctrl, 32'h00A5_005A);
  endtask

  task automatic t_mismatch;
    addr(DEV ^ 6'h01, 2'b00);
    xfer(8'd1, 8'hEE);
    chk("R4 vol_l unchanged", vol_l, 8'h22);
    chk("R4 no strobe", fcnt[1], 1);
  endtask

  task automatic t_unused_type;
    addr(DEV, 2'b01);
    xfer(8'd0, 8'h77);
    chk("R3 type 01 ignored", vol_r, 8'h11);
    addr(DEV, 2'b11);
    xfer(8'd0, 8'h78);
    xfer(8'd1, 8'h79);
    chk("R3 type 11 ignored", {vol_r, vol_l, ctrl[7:0]}, 24'h1122_5A);
  endtask

  task automatic t_partial;
    addr(DEV, 2'b00);
    set_mode(1'b1);
    send_bits(8'd2, 8);
    send_bits(8'hFF, 5);
    set_mode(1'b0);
    idle(8);
    chk("R8 cut transfer writes nothing", bass, 8'h33);
    chk("R8 no strobe on cut", fcnt[2], 1);
    xfer(8'd2, 8'h99);
    chk("R8 partial bits dropped", bass, 8'h99);
    set_mode(1'b1);
    send_bits(8'd2, 8);
    send_bits(8'h10, 8);
    send_bits(8'h20, 8);
    set_mode(1'b0);
    idle(8);
    chk("R9 third byte ignored", bass, 8'h10);
    chk("R9 strobe count", fcnt[2], 3);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin fcnt[i] = 0; ccnt[i] = 0; end
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_feature();
    t_control();
    t_mismatch();
    t_unused_type();
    t_partial();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule